// File: doc/BRIEF.md
# Processor Sleep Mode Controller

This block manages the low-power sleep state of a processor core. When the core reports that its sleep instruction has completed, the controller drops the CPU clock enable so that the core halts with its register contents intact. The peripheral clock enable and the external clock output enable stay asserted, so on-chip modules keep running while the core sleeps. A two-bit status output tells the outside world that the core is asleep.

While asleep, the controller watches three groups of interrupt sources and four reset sources. These are a non-maskable interrupt, an 8-line external interrupt level input and a set of on-chip module requests. An interrupt wakes the core even when the core's block bit is set. On an interrupt wake-up the controller restores the CPU clock enable, pulses an exception request for one cycle and latches a 12-bit event code that identifies the winning source. A reset source wakes the core without an exception request and clears the event code.

Top module: `core_sleep_ctrl`

## Requirements
- R1: After `rst_ni` is deasserted and before any stimulus, `cpu_clk_en_o`=1, `status_o`=2'b00, `exc_req_o`=0 and `evt_code_o`=0.
- R2: In execution, a `sleep_req_i` sampled with no interrupt or reset source active enters sleep on that edge: from the next cycle `cpu_clk_en_o`=0 and `status_o`=2'b10 (bit 1 high, bit 0 low). In execution `status_o`=2'b00.
- R3: `per_clk_en_o` and `clk_out_en_o` stay 1 in every state, including sleep.
- R4: A wake on `nmi_i` latches event code 12'h1C0.
- R5: A wake on the external level input latches 12'h200 + 12'h20*i, where i is the index of the highest set bit of `irq_lvl_i`.
- R6: A wake on an on-chip request latches 12'h400 + 12'h20*j, where j is the index of the highest set bit of `per_irq_i`.
- R7: When several interrupt groups are active in the same cycle, NMI wins over the level input, and the level input wins over on-chip requests.
- R8: `blk_bit_i` has no effect: interrupts wake the core and raise the exception request whether it is 0 or 1.
- R9: Any of `rst_pin_i`, `rst_wdt_i`, `rst_dbg_i`, `rst_man_i` sampled high returns the block to execution on the next cycle with `exc_req_o`=0 and `evt_code_o`=0, even when an interrupt is active in the same cycle.
- R10: The cycle after an interrupt is sampled in sleep, `cpu_clk_en_o` returns to 1 and `exc_req_o` is 1. In the cycle after that, `exc_req_o` is 0.
- R11: A `sleep_req_i` sampled while an interrupt or reset source is active is ignored, and the block stays in execution.
- R12: In sleep, with no wake source active, the block stays asleep and `evt_code_o` holds its value, whether or not `sleep_req_i` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Sleep instruction has completed |
| nmi_i | input | 1 | Non-maskable interrupt |
| irq_lvl_i | input | IRQ_W | External interrupt level lines |
| per_irq_i | input | PER_W | On-chip module interrupt requests |
| blk_bit_i | input | 1 | Status register block bit |
| rst_pin_i | input | 1 | Power-on reset from the external pin |
| rst_wdt_i | input | 1 | Power-on reset from watchdog overflow |
| rst_dbg_i | input | 1 | Debug interface reset |
| rst_man_i | input | 1 | Manual reset |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| clk_out_en_o | output | 1 | External clock output enable |
| status_o | output | 2 | External status pins |
| exc_req_o | output | 1 | One-cycle interrupt exception request |
| evt_code_o | output | 12 | Latched interrupt event code |

## Verification
The bench builds the block with its default widths of eight external level lines and four on-chip request lines. At these widths every combination of NMI, level and on-chip inputs can be swept: 8191 non-idle patterns, each entered from sleep, with the block bit alternating. This covers every priority tie and every highest-bit index, and the expected event codes are derived from the highest set bit. Each of the four reset sources is then applied alone and together with an NMI, and sleep requests are applied against pending sources and while already asleep.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam int CODE_W = 12;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t NMI_CODE  = 12'h1C0;
  localparam code_t IRQ_BASE  = 12'h200;
  localparam code_t PER_BASE  = 12'h400;
  localparam code_t CODE_STEP = 12'h020;

  typedef enum logic {ST_RUN = 1'b0, ST_SLEEP = 1'b1} slp_state_e;

  function automatic code_t idx_code(code_t base, int idx);
    return base + code_t'(idx) * CODE_STEP;
  endfunction
endpackage

// File: rtl/sleep_wake_detect.sv
module sleep_wake_detect
  import sleep_pkg::*;
#(
  parameter int IRQ_W = 8,
  parameter int PER_W = 4,
  parameter int RST_N = 4
) (
  input  logic             nmi_i,
  input  logic [IRQ_W-1:0] irq_lvl_i,
  input  logic [PER_W-1:0] per_irq_i,
  input  logic [RST_N-1:0] rst_src_i,
  output logic             int_any_o,
  output logic             rst_any_o,
  output code_t            code_o
);
  localparam int IRQ_IW = (IRQ_W > 1) ? $clog2(IRQ_W) : 1;
  localparam int PER_IW = (PER_W > 1) ? $clog2(PER_W) : 1;

  logic [IRQ_IW-1:0] irq_idx;
  logic [PER_IW-1:0] per_idx;

  // highest set index wins within each group
  always_comb begin
    irq_idx = '0;
    for (int i = 0; i < IRQ_W; i++)
      if (irq_lvl_i[i]) irq_idx = IRQ_IW'(i);
  end

  always_comb begin
    per_idx = '0;
    for (int j = 0; j < PER_W; j++)
      if (per_irq_i[j]) per_idx = PER_IW'(j);
  end

  assign int_any_o = nmi_i | (|irq_lvl_i) | (|per_irq_i);
  assign rst_any_o = |rst_src_i;

  always_comb begin
    if (nmi_i)             code_o = NMI_CODE;
    else if (|irq_lvl_i)   code_o = idx_code(IRQ_BASE, int'(irq_idx));
    else if (|per_irq_i)   code_o = idx_code(PER_BASE, int'(per_idx));
    else                   code_o = '0;
  end

  always_comb begin
    if (nmi_i) assert_nmi_code_R4: assert (code_o == NMI_CODE);
    if (!nmi_i && (|irq_lvl_i))
      assert_irq_over_per_R7: assert (code_o[CODE_W-1:8] == IRQ_BASE[CODE_W-1:8]);
  end
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sleep_req_i,
  input  logic  int_any_i,
  input  logic  rst_any_i,
  input  code_t code_i,
  output logic  asleep_o,
  output logic  exc_req_o,
  output code_t code_o
);
  slp_state_e state_q, state_d;
  logic  exc_q, exc_d;
  code_t code_q, code_d;

  always_comb begin
    state_d = state_q;
    exc_d   = 1'b0;
    code_d  = code_q;
    if (rst_any_i) begin
      state_d = ST_RUN;
      code_d  = '0;
    end else begin
      unique case (state_q)
        ST_RUN:   if (sleep_req_i && !int_any_i) state_d = ST_SLEEP;
        ST_SLEEP: if (int_any_i) begin
          state_d = ST_RUN;
          exc_d   = 1'b1;
          code_d  = code_i;
        end
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      exc_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      exc_q   <= exc_d;
      code_q  <= code_d;
    end
  end

  assign asleep_o  = (state_q == ST_SLEEP);
  assign exc_req_o = exc_q;
  assign code_o    = code_q;

  assert_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_o && sleep_req_i && !int_any_i && !rst_any_i) |=> asleep_o);
  assert_rst_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_any_i |=> (!asleep_o && !exc_req_o && code_o == '0));
  assert_int_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && int_any_i && !rst_any_i) |=> (!asleep_o && exc_req_o));
  assert_exc_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |=> !exc_req_o);
  assert_ignore_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_o && (int_any_i || rst_any_i)) |=> !asleep_o);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && !int_any_i && !rst_any_i) |=> (asleep_o && $stable(code_o)));
endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int IRQ_W = 8,
  parameter int PER_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              nmi_i,
  input  logic [IRQ_W-1:0]  irq_lvl_i,
  input  logic [PER_W-1:0]  per_irq_i,
  input  logic              blk_bit_i,
  input  logic              rst_pin_i,
  input  logic              rst_wdt_i,
  input  logic              rst_dbg_i,
  input  logic              rst_man_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              clk_out_en_o,
  output logic [1:0]        status_o,
  output logic              exc_req_o,
  output logic [CODE_W-1:0] evt_code_o
);
  localparam int RST_N = 4;

  logic [RST_N-1:0] rst_src;
  logic  int_any, rst_any, asleep;
  code_t wake_code;

  assign rst_src = {rst_man_i, rst_dbg_i, rst_wdt_i, rst_pin_i};

  sleep_wake_detect #(.IRQ_W(IRQ_W), .PER_W(PER_W), .RST_N(RST_N)) u_detect (
    .nmi_i     (nmi_i),
    .irq_lvl_i (irq_lvl_i),
    .per_irq_i (per_irq_i),
    .rst_src_i (rst_src),
    .int_any_o (int_any),
    .rst_any_o (rst_any),
    .code_o    (wake_code)
  );

  sleep_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .int_any_i   (int_any),
    .rst_any_i   (rst_any),
    .code_i      (wake_code),
    .asleep_o    (asleep),
    .exc_req_o   (exc_req_o),
    .code_o      (evt_code_o)
  );

  // core halts; peripherals and clock pin keep running
  assign cpu_clk_en_o = !asleep;
  assign per_clk_en_o = 1'b1;
  assign clk_out_en_o = 1'b1;
  assign status_o     = asleep ? 2'b10 : 2'b00;

  // block bit must not hold off a wake
  assert_blk_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && blk_bit_i && int_any && !rst_any) |=> (exc_req_o && cpu_clk_en_o));
  assert_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b10) |-> !cpu_clk_en_o);
endmodule

// File: tb/sim_core_sleep_ctrl.sv
module sim_core_sleep_ctrl;
  localparam int CLK_P = 10;
  localparam int IRQ_W = 8;
  localparam int PER_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sleep_req_i = 0, nmi_i = 0, blk_bit_i = 0;
  logic [IRQ_W-1:0] irq_lvl_i = '0;
  logic [PER_W-1:0] per_irq_i = '0;
  logic rst_pin_i = 0, rst_wdt_i = 0, rst_dbg_i = 0, rst_man_i = 0;
  logic cpu_clk_en_o, per_clk_en_o, clk_out_en_o, exc_req_o;
  logic [1:0] status_o;
  logic [11:0] evt_code_o;

  int checks = 0, errors = 0;
  bit done = 0;

  core_sleep_ctrl #(.IRQ_W(IRQ_W), .PER_W(PER_W)) u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    sleep_req_i = 0; nmi_i = 0; irq_lvl_i = '0; per_irq_i = '0;
    rst_pin_i = 0; rst_wdt_i = 0; rst_dbg_i = 0; rst_man_i = 0;
  endtask

  task automatic go_sleep();
    quiet(); sleep_req_i = 1; tick(); sleep_req_i = 0;
  endtask

  function automatic int msb(int v);
    return $clog2(v + 1) - 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(3*CLK_P) rst_ni = 1; #1;
    // R1
    chk("R1 cpu_en", cpu_clk_en_o, 1);
    chk("R1 status", status_o, 0);
    chk("R1 exc", exc_req_o, 0);
    chk("R1 code", evt_code_o, 0);
    tick();

    // R2, R3
    go_sleep();
    chk("R2 cpu_en", cpu_clk_en_o, 0);
    chk("R2 status", status_o, 2);
    chk("R3 per_en", per_clk_en_o, 1);
    chk("R3 clkout_en", clk_out_en_o, 1);

    // R12: sleep request while asleep, no source
    sleep_req_i = 1; tick(); tick(); sleep_req_i = 0; tick();
    chk("R12 asleep", status_o, 2);
    chk("R12 code", evt_code_o, 0);
    nmi_i = 1; tick(); nmi_i = 0; tick();

    // R4-R8, R10: full sweep
    for (int n = 0; n < 2; n++)
      for (int q = 0; q < (1 << IRQ_W); q++)
        for (int p = 0; p < (1 << PER_W); p++) begin
          int exp;
          string tag;
          if (n == 0 && q == 0 && p == 0) continue;
          if (n != 0)      begin exp = 'h1C0; tag = "R4"; end
          else if (q != 0) begin exp = 'h200 + 'h20 * msb(q); tag = "R5"; end
          else             begin exp = 'h400 + 'h20 * msb(p); tag = "R6"; end
          if ((n + (q != 0) + (p != 0)) > 1) tag = {tag, " R7"};
          go_sleep();
          blk_bit_i = ((q ^ p) & 1) != 0;
          if (status_o != 2) chk("R2 enter", status_o, 2);
          nmi_i = n[0]; irq_lvl_i = q[IRQ_W-1:0]; per_irq_i = p[PER_W-1:0];
          tick();
          quiet();
          chk({tag, " R8 code"}, evt_code_o, exp);
          if (cpu_clk_en_o !== 1 || exc_req_o !== 1) begin
            chk("R10 wake cpu_en", cpu_clk_en_o, 1);
            chk("R10 wake exc", exc_req_o, 1);
          end
          tick();
          if (exc_req_o !== 0) chk("R10 pulse", exc_req_o, 0);
        end
    blk_bit_i = 1;
    go_sleep(); per_irq_i = 4'b0001; tick(); quiet();
    chk("R8 blk wake exc", exc_req_o, 1);
    chk("R10 cpu_en", cpu_clk_en_o, 1);
    tick();
    chk("R10 pulse end", exc_req_o, 0);
    chk("R10 code held", evt_code_o, 'h400);

    // R9: each reset source, alone and with NMI
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < 2; w++) begin
        go_sleep();
        nmi_i = w[0];
        rst_pin_i = (k == 0); rst_wdt_i = (k == 1);
        rst_dbg_i = (k == 2); rst_man_i = (k == 3);
        tick(); quiet();
        chk("R9 cpu_en", cpu_clk_en_o, 1);
        chk("R9 exc", exc_req_o, 0);
        chk("R9 code", evt_code_o, 0);
        chk("R9 status", status_o, 0);
        tick();
      end

    // R11: request against pending sources
    quiet(); sleep_req_i = 1; irq_lvl_i = 8'h10; tick(); quiet(); tick();
    chk("R11 irq pending", cpu_clk_en_o, 1);
    sleep_req_i = 1; rst_wdt_i = 1; tick(); quiet(); tick();
    chk("R11 rst pending", status_o, 0);
    sleep_req_i = 1; per_irq_i = 4'b1000; tick(); quiet(); tick();
    chk("R11 per pending", cpu_clk_en_o, 1);
    chk("R11 no exc", exc_req_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule